// File: doc/BRIEF.md
# Prioritized Address Translation Window Unit

This unit turns a 34-bit inbound request address into a 32-bit local bus address. It uses a bank of programmable windows. Each window holds three registers:

- a base, whose two extra upper bits extend it to 34 bits;
- a mask, which also carries two extra upper bits and an enable flag;
- an offset.

A parameter sets how many windows exist, from 1 to 16. A single-cycle write port programs the windows.

A request is presented for one cycle. All enabled windows compare against it in parallel, and the lowest-numbered matching window wins. The local address takes the offset bits where the mask is set and the request address bits where it is clear. Bit 2 of the result depends on the datapath width, and on the word pointer and size for narrow accesses. Reads and writes-with-response that hit no window raise an error-response request. The result comes out one cycle later with a valid strobe.

The output sequencer has two states:

- IDLE means no result is on the outputs.
- EMIT means a registered result is being presented.

The transitions are:

- IDLE to EMIT on a request.
- EMIT to EMIT on a back-to-back request.
- EMIT to IDLE when no request arrives.
- IDLE to IDLE while the request input stays low.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset, `out_valid` and `out_err` are 0 and every window is disabled.
- R2: A request sampled with `req_valid`=1 on a clock edge gives `out_valid`=1 after the next edge, together with hit, index, address and error. A cycle without a request gives `out_valid`=0 a cycle later.
- R3: A window matches when (addr AND {mask_ext, mask}) equals ({base_ext, base} AND {mask_ext, mask}). The extension fields are `cfg_wdata[33:32]` of base and mask writes.
- R4: When several enabled windows match, the lowest index is reported on `out_win` and used for translation.
- R5: A window takes part only while the enable bit (`cfg_wdata[34]` of its last mask write) is 1. Rewriting the mask with the bit cleared removes the window from matching.
- R6: On a hit, `out_addr[31:3]` = (offset[31:3] AND mask[31:3]) OR (addr[31:3] AND NOT mask[31:3]).
- R7: Bits [2:0] of base, mask and offset are stored as zero whatever is written. Low request address bits therefore never affect matching, and offset bits [2:0] never reach the output.
- R8: `out_addr[1:0]` is always 0. With `DATAPATH_BITS`=64, `out_addr[2]` is 0.
- R9: With `DATAPATH_BITS`=32, `out_addr[2]` equals `req_wdptr` for sizes 1, 2 and 4 bytes (`req_size` 0, 1, 2). It is 0 for 8-byte accesses (`req_size`=3).
- R10: `out_err`=1 only on a miss whose `req_kind` is read (2'b00) or write-with-response (2'b10). Writes without response (2'b01) and other kinds (2'b11) never raise it.
- R11: Writes with `cfg_win` at or above `NUM_WIN` change nothing.
- R12: On a miss, `out_addr` and `out_win` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 4 | Window index of the write |
| cfg_sel | input | 2 | 0 base, 1 mask, 2 offset, 3 none |
| cfg_wdata | input | 35 | [31:0] address bits, [33:32] extension, [34] enable (mask only) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 34 | Inbound address |
| req_kind | input | 2 | 00 read, 01 write, 10 write with response, 11 other |
| req_wdptr | input | 1 | Word pointer |
| req_size | input | 2 | Access size code: 0 1B, 1 2B, 2 4B, 3 8B |
| out_valid | output | 1 | Result strobe |
| out_hit | output | 1 | A window matched |
| out_win | output | 4 | Index of the matching window |
| out_addr | output | 32 | Translated local address |
| out_err | output | 1 | Error response needed |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Overlapping windows where a higher-index window is narrower.** A wrong priority order would report the more specific window.
- **Addresses differing only in the two extension bits.** A design that ignored the extension bits would report a hit where a miss is due.
- **Windows disabled by a mask rewrite.** A design that ignored the enable bit would still report the disabled window.
- **Registers written with nonzero low bits.** A design that kept those bits would let low request address bits spoil the match or let offset bits leak into the output.
- **Bit 2 across all sizes and both datapath widths.** Mistakes here move the address by one word.
- **Window writes past the configured count on a four-window instance.** A design that accepted them would gain phantom hits.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int IN_AW  = 34;
    localparam int OUT_AW = 32;
    localparam int IDX_W  = 4;
    localparam int CFG_W  = 35;

    typedef enum logic [1:0] {
        KIND_READ    = 2'b00,
        KIND_WRITE   = 2'b01,
        KIND_WRITE_R = 2'b10,
        KIND_OTHER   = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'b00,
        SEL_MASK   = 2'b01,
        SEL_OFFSET = 2'b10,
        SEL_NONE   = 2'b11
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    typedef struct packed {
        logic        en;
        logic [1:0]  mext;
        logic [31:0] mask;
        logic [1:0]  bext;
        logic [31:0] base;
        logic [31:0] offset;
    } win_cfg_t;
endpackage

// File: rtl/xlat_regbank.sv
`timescale 1ns/1ps
module xlat_regbank
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_win,
    input  logic [1:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output win_cfg_t            cfg_o [NUM_WIN]
);
    localparam logic [31:0] LOW_CLR = 32'hFFFF_FFF8;

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        win_cfg_t r;
        logic     wr_here;
        assign wr_here = cfg_we && (cfg_win == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_here) begin
                unique case (sel)
                    SEL_BASE: begin
                        r.base <= cfg_wdata[31:0] & LOW_CLR;
                        r.bext <= cfg_wdata[33:32];
                    end
                    SEL_MASK: begin
                        r.mask <= cfg_wdata[31:0] & LOW_CLR;
                        r.mext <= cfg_wdata[33:32];
                        r.en   <= cfg_wdata[34];
                    end
                    SEL_OFFSET: r.offset <= cfg_wdata[31:0] & LOW_CLR;
                    SEL_NONE:   ;
                endcase
            end
        end
        assign cfg_o[g] = r;

        // R1: disabled right after reset
        AST_RESET_DISABLED: assert property (@(posedge clk)
            !rst_n |=> !r.en) else $error("AST_RESET_DISABLED"); // R1
    end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  win_cfg_t            cfg_i [NUM_WIN],
    input  logic [IN_AW-1:0]    addr_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [31:3]         mask_o,
    output logic [31:3]         off_o
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [IN_AW-1:0] m, b;
        assign m = {cfg_i[g].mext, cfg_i[g].mask};
        assign b = {cfg_i[g].bext, cfg_i[g].base};
        assign hit_vec[g] = cfg_i[g].en && ((addr_i & m) == (b & m));
    end

    // scan downward so the lowest matching index is the last assignment
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        mask_o = '0;
        off_o  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                mask_o = cfg_i[i].mask[31:3];
                off_o  = cfg_i[i].offset[31:3];
            end
        end
    end
endmodule

// File: rtl/xlat_addr.sv
`timescale 1ns/1ps
module xlat_addr
    import xlat_pkg::*;
#(
    parameter int DATAPATH_BITS = 64
) (
    input  logic [31:3]        addr_hi,
    input  logic [31:3]        mask_hi,
    input  logic [31:3]        off_hi,
    input  logic               wdptr,
    input  logic [1:0]         size,
    output logic [OUT_AW-1:0]  addr_o
);
    logic bit2;

    if (DATAPATH_BITS == 32) begin : g_narrow
        assign bit2 = (size != 2'b11) ? wdptr : 1'b0;
    end else begin : g_wide
        logic unused_narrow;
        assign unused_narrow = ^{wdptr, size};
        assign bit2 = 1'b0;
    end

    assign addr_o = {(off_hi & mask_hi) | (addr_hi & ~mask_hi), bit2, 2'b00};
endmodule

// File: rtl/xlat_window_unit.sv
`timescale 1ns/1ps
module xlat_window_unit
    import xlat_pkg::*;
#(
    parameter int NUM_WIN       = 16,
    parameter int DATAPATH_BITS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_win,
    input  logic [1:0]  cfg_sel,
    input  logic [34:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [33:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic        req_wdptr,
    input  logic [1:0]  req_size,
    output logic        out_valid,
    output logic        out_hit,
    output logic [3:0]  out_win,
    output logic [31:0] out_addr,
    output logic        out_err
);
    win_cfg_t           cfg [NUM_WIN];
    logic               m_hit;
    logic [IDX_W-1:0]   m_idx;
    logic [31:3]        m_mask, m_off;
    logic [OUT_AW-1:0]  x_addr;
    logic               err_kind;

    xlat_regbank #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_o(cfg)
    );

    xlat_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg_i(cfg), .addr_i(req_addr), .hit_o(m_hit), .idx_o(m_idx),
        .mask_o(m_mask), .off_o(m_off)
    );

    xlat_addr #(.DATAPATH_BITS(DATAPATH_BITS)) u_addr (
        .addr_hi(req_addr[31:3]), .mask_hi(m_mask), .off_hi(m_off),
        .wdptr(req_wdptr), .size(req_size), .addr_o(x_addr)
    );

    req_kind_e kind;
    assign kind     = req_kind_e'(req_kind);
    assign err_kind = (kind == KIND_READ) || (kind == KIND_WRITE_R);

    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic               hit_q, err_q;
    logic [IDX_W-1:0]   win_q;
    logic [OUT_AW-1:0]  addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            err_q  <= 1'b0;
            win_q  <= '0;
            addr_q <= '0;
        end else if (req_valid) begin
            hit_q  <= m_hit;
            err_q  <= !m_hit && err_kind;
            win_q  <= m_hit ? m_idx  : '0;
            addr_q <= m_hit ? x_addr : '0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_hit   = out_valid && hit_q;
    assign out_err   = out_valid && err_q;
    assign out_win   = win_q;
    assign out_addr  = addr_q;

    AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid) else $error("AST_LATENCY"); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid) else $error("AST_NO_SPURIOUS"); // R2
    AST_ERR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && !out_hit)) else $error("AST_ERR_ON_MISS"); // R10
    AST_WIN_RANGE:  assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (32'(out_win) < NUM_WIN)) else $error("AST_WIN_RANGE"); // R4
    AST_LOW_BITS:   assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[1:0] == 2'b00)) else $error("AST_LOW_BITS"); // R8
    AST_MISS_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_addr == '0 && out_win == '0)) else $error("AST_MISS_ZERO"); // R12

    if (DATAPATH_BITS == 64) begin : g_chk_wide
        AST_BIT2_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !out_addr[2]) else $error("AST_BIT2_WIDE"); // R8
    end else begin : g_chk_narrow
        AST_BIT2_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_size == 2'b11) |=> !out_addr[2]) else $error("AST_BIT2_FULL"); // R9
    end
endmodule

// File: tb/sim_xlat_window_unit.sv
`timescale 1ns/1ps
module sim_xlat_window_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = 2'b11;
    logic [34:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [33:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_wdptr = 1'b0;
    logic [1:0]  req_size = '0;

    logic        v0, h0, e0, v1, h1, e1;
    logic [3:0]  w0, w1;
    logic [31:0] a0, a1;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    xlat_window_unit #(.NUM_WIN(16), .DATAPATH_BITS(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_wdptr(req_wdptr), .req_size(req_size), .out_valid(v0), .out_hit(h0),
        .out_win(w0), .out_addr(a0), .out_err(e0));

    xlat_window_unit #(.NUM_WIN(4), .DATAPATH_BITS(64)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_wdptr(req_wdptr), .req_size(req_size), .out_valid(v1), .out_hit(h1),
        .out_win(w1), .out_addr(a1), .out_err(e1));

    // bench model of the window registers
    logic [31:0] m_base [16];
    logic [31:0] m_mask [16];
    logic [31:0] m_off  [16];
    logic [1:0]  m_bext [16];
    logic [1:0]  m_mext [16];
    logic        m_en   [16];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(int win, int sel, logic [34:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 4'(win); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) begin m_base[win] = d[31:0] & ~32'h7; m_bext[win] = d[33:32]; end
        if (sel == 1) begin m_mask[win] = d[31:0] & ~32'h7; m_mext[win] = d[33:32]; m_en[win] = d[34]; end
        if (sel == 2) m_off[win] = d[31:0] & ~32'h7;
    endtask

    task automatic ref_xlat(int nw, int dp, logic [33:0] a, logic [1:0] k, logic wp, logic [1:0] sz,
                            output logic hit, output logic [3:0] idx,
                            output logic [31:0] oa, output logic err);
        hit = 1'b0; idx = '0; oa = '0;
        for (int i = 0; i < nw; i++) begin
            if (!hit && m_en[i] &&
                ((a & {m_mext[i], m_mask[i]}) == ({m_bext[i], m_base[i]} & {m_mext[i], m_mask[i]}))) begin
                hit = 1'b1;
                idx = 4'(i);
            end
        end
        if (hit) begin
            oa[31:3] = (m_off[idx][31:3] & m_mask[idx][31:3]) | (a[31:3] & ~m_mask[idx][31:3]);
            oa[2]    = (dp == 32 && sz != 2'b11) ? wp : 1'b0;
        end
        err = !hit && (k == 2'b00 || k == 2'b10);
    endtask

    task automatic do_req(string tag, logic [33:0] a, logic [1:0] k, logic wp, logic [1:0] sz);
        logic eh0, eh1, ee0, ee1;
        logic [3:0] ei0, ei1;
        logic [31:0] ea0, ea1;
        ref_xlat(16, 32, a, k, wp, sz, eh0, ei0, ea0, ee0);
        ref_xlat(4, 64, a, k, wp, sz, eh1, ei1, ea1, ee1);
        @(negedge clk);
        chk({tag, " R2 idle valid"}, 64'(v0), 64'd0);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_wdptr = wp; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 u0 valid"}, 64'(v0), 64'd1);
        chk({tag, " R3 u0 hit"},   64'(h0), 64'(eh0));
        chk({tag, " R4 u0 win"},   64'(w0), 64'(ei0));
        chk({tag, " R6 u0 addr"},  64'(a0), 64'(ea0));
        chk({tag, " R10 u0 err"},  64'(e0), 64'(ee0));
        chk({tag, " R2 u1 valid"}, 64'(v1), 64'd1);
        chk({tag, " R3 u1 hit"},   64'(h1), 64'(eh1));
        chk({tag, " R4 u1 win"},   64'(w1), 64'(ei1));
        chk({tag, " R8 u1 addr"},  64'(a1), 64'(ea1));
        chk({tag, " R10 u1 err"},  64'(e1), 64'(ee1));
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_off[i] = '0;
            m_bext[i] = '0; m_mext[i] = '0; m_en[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 u0 valid", 64'(v0), 64'd0);
        chk("R1 u0 err",   64'(e0), 64'd0);
        chk("R1 u1 valid", 64'(v1), 64'd0);

        // nothing programmed: all miss
        do_req("R1 R12 empty read", 34'h1_2345_6789, 2'b00, 1'b0, 2'b10);
        do_req("R10 empty write",   34'h1_2345_6789, 2'b01, 1'b0, 2'b10);
        do_req("R10 empty other",   34'h1_2345_6789, 2'b11, 1'b0, 2'b10);
        do_req("R10 empty write_r", 34'h1_2345_6789, 2'b10, 1'b0, 2'b10);

        // window 0 with extension bits
        cfg_write(0, 0, {1'b0, 2'b10, 32'h1000_0000});
        cfg_write(0, 1, {1'b1, 2'b11, 32'hF000_0000});
        cfg_write(0, 2, {1'b0, 2'b00, 32'h8000_0000});
        do_req("R3 R6 w0 hit",       {2'b10, 32'h1234_5678}, 2'b00, 1'b1, 2'b10);
        do_req("R3 ext mismatch",    {2'b01, 32'h1234_5678}, 2'b00, 1'b1, 2'b10);
        do_req("R9 size8 wdptr1",    {2'b10, 32'h1ABC_DEF0}, 2'b10, 1'b1, 2'b11);
        do_req("R9 size1 wdptr1",    {2'b10, 32'h1ABC_DEF0}, 2'b10, 1'b1, 2'b00);
        do_req("R9 size2 wdptr0",    {2'b10, 32'h1ABC_DEF4}, 2'b00, 1'b0, 2'b01);
        do_req("R10 hit no err",     {2'b10, 32'h1000_0000}, 2'b00, 1'b0, 2'b10);

        // priority: broad w1 vs narrow w3; w5 beyond u1 range
        cfg_write(1, 0, {1'b0, 2'b00, 32'h2000_0000});
        cfg_write(1, 1, {1'b1, 2'b00, 32'hF000_0000});
        cfg_write(1, 2, {1'b0, 2'b00, 32'h5000_0000});
        cfg_write(3, 0, {1'b0, 2'b00, 32'h2000_0000});
        cfg_write(3, 1, {1'b1, 2'b00, 32'hFF00_0000});
        cfg_write(3, 2, {1'b0, 2'b00, 32'h4000_0000});
        cfg_write(5, 0, {1'b0, 2'b00, 32'h3000_0000});
        cfg_write(5, 1, {1'b1, 2'b00, 32'hF000_0000});
        cfg_write(5, 2, {1'b0, 2'b00, 32'h9000_0000});
        do_req("R4 lowest wins",     {2'b00, 32'h2012_3450}, 2'b00, 1'b0, 2'b11);
        do_req("R11 w5 only u0",     {2'b00, 32'h3456_7890}, 2'b00, 1'b0, 2'b11);
        cfg_write(1, 1, {1'b0, 2'b00, 32'hF000_0000});
        do_req("R5 w1 disabled",     {2'b00, 32'h2012_3450}, 2'b00, 1'b0, 2'b11);
        do_req("R5 w1 region miss",  {2'b00, 32'h2812_3450}, 2'b00, 1'b0, 2'b11);

        // low register bits forced to zero
        cfg_write(2, 0, {1'b0, 2'b11, 32'h6000_0005});
        cfg_write(2, 1, {1'b1, 2'b00, 32'hF000_0007});
        cfg_write(2, 2, {1'b0, 2'b00, 32'h0000_0007});
        do_req("R7 low bits",        {2'b01, 32'h6000_0000}, 2'b00, 1'b1, 2'b11);
        do_req("R7 R9 low bits",     {2'b00, 32'h6000_0003}, 2'b00, 1'b1, 2'b01);

        // random configuration and traffic
        for (int w = 0; w < 16; w++) begin
            cfg_write(w, 0, {1'b0, 2'($urandom), 32'($urandom)});
            cfg_write(w, 1, {($urandom % 4) != 0, 2'($urandom), 32'hFFFF_FFFF << (12 + $urandom % 16)});
            cfg_write(w, 2, {3'b000, 32'($urandom)});
        end
        for (int n = 0; n < 300; n++) begin
            logic [33:0] a, m, r;
            if (n % 60 == 59) begin
                int w = $urandom % 16;
                cfg_write(w, 1, {1'b0, m_mext[w], m_mask[w]});
                cfg_write(w, 0, {1'b0, 2'($urandom), 32'($urandom)});
                cfg_write(w, 1, {1'b1, 2'($urandom), 32'hFFFF_FFFF << (8 + $urandom % 20)});
            end
            r = {2'($urandom), 32'($urandom)};
            if ($urandom % 3 != 0) begin
                int w = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 16);
                m = {m_mext[w], m_mask[w]};
                a = ({m_bext[w], m_base[w]} & m) | (r & ~m);
            end else begin
                a = r;
            end
            do_req("R3 R4 R6 R9 random", a, 2'($urandom), 1'($urandom), 2'($urandom));
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule